// File: doc/BRIEF.md
# Delay-Line Period Hit Detector

This block sits after the sampling stage of a digital clock multiplier's delay line. Each bit of its input vector belongs to one tap of the line. A bit is set when the reference pulse lines up with the delayed clock at that tap. The block examines only the lower half of the taps. Among those, it picks the tap whose delay equals one full input-clock period. The index of that tap sets the quarter, half and three-quarter taps further down the chain.

At higher input frequencies several examined taps can coincide. The lowest index among them is the true period tap, and the block keeps only that one. Two outcomes mean the block cannot resolve a period. If no examined tap coincides, the period is longer than the line. If every examined tap coincides, the period is too short. The block reports the tap index, a valid flag, an odd-index flag, and one flag for each of the two failure outcomes.

A two-state machine controls the result. After reset or a synchronous clear it sits in `ST_EMPTY`, and every output is zero. On a latch strobe it takes the `CAPTURE` transition to `ST_HELD` and registers the classified result. It then ignores further strobes until a clear takes the `RELEASE` transition back to `ST_EMPTY`. When clear and latch arrive in the same cycle, clear wins.

Top module: `period_hit_detector`

## Requirements
- R1: After reset, and in the cycle after a clear, the block is in `ST_EMPTY`. In that state `h_index`, `h_valid`, `h_odd`, `overflow` and `underflow` are all 0.
- R2: Only taps 0 to N/2-1 (0 to 31 at N=64) take part. A set bit at tap N/2 or above has no effect on any output.
- R3: When one or more examined taps are set, `h_index` is the binary index of the lowest set examined tap.
- R4: When `h_valid` is 1, `h_odd` equals bit 0 of `h_index`, so it is 1 for an odd tap index. In every other case `h_odd` is 0.
- R5: A captured vector with no examined tap set gives `overflow`=1, `h_valid`=0 and `h_index`=0.
- R6: A captured vector with every examined tap set gives `underflow`=1, `h_valid`=0 and `h_index`=0.
- R7: `overflow` and `underflow` are never 1 together. `h_valid` is 1 exactly when a result is held and neither flag is set.
- R8: A latch strobe sampled at a rising edge changes the outputs at that same edge. A change of `tap_hits` without a strobe has no effect on the outputs.
- R9: In `ST_HELD`, further latch strobes are ignored until a clear.
- R10: When clear and latch are both high in the same cycle, clear wins and the block ends in `ST_EMPTY`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous frame clear; returns the block to `ST_EMPTY` |
| latch | input | 1 | Capture strobe; one per measurement |
| tap_hits | input | N | Coincidence bit for each delay-line tap |
| h_index | output | $clog2(N) | Index of the lowest examined tap that is set |
| h_valid | output | 1 | A held result is usable |
| h_odd | output | 1 | The held valid index is odd |
| overflow | output | 1 | No examined tap was set |
| underflow | output | 1 | Every examined tap was set |

## Verification
Every result is due one register stage after its strobe. A latch or clear sampled at a rising edge shows up on the outputs right after that edge. The bench therefore drives inputs on the falling edge and reads the outputs on the next falling edge. The timing check also reads the outputs half a cycle before the capturing edge, which confirms that nothing leaks through combinationally. The checks for hold and ignore first change `tap_hits`, or pulse the latch, and then wait a full cycle before reading, so any wrong update would already be visible.

// File: rtl/period_hit_pkg.sv
package period_hit_pkg;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_HELD  = 1'b1
    } hold_state_t;

    typedef struct packed {
        logic valid;
        logic odd;
        logic over;
        logic under;
    } hit_flags_t;

endpackage

// File: rtl/first_hit_finder.sv
module first_hit_finder #(
    parameter int SPAN = 32,
    parameter int IW   = 6
) (
    input  logic [SPAN-1:0] taps,
    output logic [IW-1:0]   first_idx,
    output logic            any_hit,
    output logic            all_hit
);
    logic [SPAN:0]   seen;
    logic [SPAN-1:0] first_mask;

    assign seen[0] = 1'b0;

    // Prefix chain: a tap is "first" when no lower tap has been seen.
    for (genvar g = 0; g < SPAN; g++) begin : g_prefix
        assign seen[g+1]     = seen[g] | taps[g];
        assign first_mask[g] = taps[g] & ~seen[g];
    end

    always_comb begin
        first_idx = '0;
        for (int i = 0; i < SPAN; i++) begin
            if (first_mask[i]) first_idx = first_idx | IW'(i);
        end
    end

    assign any_hit = seen[SPAN];
    assign all_hit = &taps;
endmodule

// File: rtl/hit_classify.sv
module hit_classify
    import period_hit_pkg::*;
#(
    parameter int IW = 6
) (
    input  logic [IW-1:0] first_idx,
    input  logic          any_hit,
    input  logic          all_hit,
    output logic [IW-1:0] idx_out,
    output hit_flags_t    flags
);
    always_comb begin
        flags.over  = ~any_hit;
        flags.under = any_hit & all_hit;
        flags.valid = any_hit & ~all_hit;
        flags.odd   = flags.valid & first_idx[0];
        idx_out     = flags.valid ? first_idx : '0;
    end
endmodule

// File: rtl/period_hit_detector.sv
module period_hit_detector
    import period_hit_pkg::*;
#(
    parameter int N = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 latch,
    input  logic [N-1:0]         tap_hits,
    output logic [$clog2(N)-1:0] h_index,
    output logic                 h_valid,
    output logic                 h_odd,
    output logic                 overflow,
    output logic                 underflow
);
    localparam int SPAN = N / 2;
    localparam int HW   = $clog2(N);

    hold_state_t state_q, state_d;

    logic [HW-1:0] first_idx, cls_idx;
    logic          any_hit, all_hit;
    hit_flags_t    cls_flags;
    logic          unused_upper;

    assign unused_upper = ^tap_hits[N-1:SPAN];

    first_hit_finder #(.SPAN(SPAN), .IW(HW)) u_find (
        .taps      (tap_hits[SPAN-1:0]),
        .first_idx (first_idx),
        .any_hit   (any_hit),
        .all_hit   (all_hit)
    );

    hit_classify #(.IW(HW)) u_cls (
        .first_idx (first_idx),
        .any_hit   (any_hit),
        .all_hit   (all_hit),
        .idx_out   (cls_idx),
        .flags     (cls_flags)
    );

    // Next-state logic: CAPTURE (EMPTY->HELD), RELEASE (HELD->EMPTY)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (!clear && latch) state_d = ST_HELD;
            ST_HELD:  if (clear)           state_d = ST_EMPTY;
            default:                       state_d = ST_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_index   <= '0;
            h_valid   <= 1'b0;
            h_odd     <= 1'b0;
            overflow  <= 1'b0;
            underflow <= 1'b0;
        end else if (clear) begin
            h_index   <= '0;
            h_valid   <= 1'b0;
            h_odd     <= 1'b0;
            overflow  <= 1'b0;
            underflow <= 1'b0;
        end else if (state_q == ST_EMPTY && latch) begin
            h_index   <= cls_idx;
            h_valid   <= cls_flags.valid;
            h_odd     <= cls_flags.odd;
            overflow  <= cls_flags.over;
            underflow <= cls_flags.under;
        end
    end
endmodule

// File: rtl/period_hit_chk.sv
module period_hit_chk #(
    parameter int HW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clear,
    input logic          latch,
    input logic [HW-1:0] h_index,
    input logic          h_valid,
    input logic          h_odd,
    input logic          overflow,
    input logic          underflow
);
    logic [HW+3:0] outs;
    assign outs = {h_index, h_valid, h_odd, overflow, underflow};

    // R1
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (outs == '0));

    // R4
    odd_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_odd == (h_valid & h_index[0]));

    // R5
    overflow_zero_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (h_index == '0 && !h_valid));

    // R6
    underflow_zero_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> (h_index == '0 && !h_valid));

    // R7
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(overflow && underflow));

    // R8
    no_strobe_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch && !clear) |=> $stable(outs));

    // R9
    held_ignores_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && (h_valid || overflow || underflow)) |=> $stable(outs));
endmodule

bind period_hit_detector period_hit_chk #(.HW(HW)) u_period_hit_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .latch     (latch),
    .h_index   (h_index),
    .h_valid   (h_valid),
    .h_odd     (h_odd),
    .overflow  (overflow),
    .underflow (underflow)
);

// File: tb/test_period_hit_detector.sv
module test_period_hit_detector;
    localparam int N    = 64;
    localparam int SPAN = N / 2;
    localparam int HW   = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clear = 1'b0;
    logic          latch = 1'b0;
    logic [N-1:0]  tap_hits = '0;
    logic [HW-1:0] h_index;
    logic          h_valid, h_odd, overflow, underflow;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    period_hit_detector #(.N(N)) i_period_hit_detector (
        .clk(clk), .rst_n(rst_n), .clear(clear), .latch(latch),
        .tap_hits(tap_hits), .h_index(h_index), .h_valid(h_valid),
        .h_odd(h_odd), .overflow(overflow), .underflow(underflow)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Pack all outputs as {h_index, valid, odd, over, under}
    function automatic int outs();
        return int'({h_index, h_valid, h_odd, overflow, underflow});
    endfunction

    function automatic int expect_outs(input logic [N-1:0] v);
        int idx = -1;
        int cnt = 0;
        for (int i = 0; i < SPAN; i++) begin
            if (v[i]) begin
                cnt++;
                if (idx < 0) idx = i;
            end
        end
        if (cnt == 0)    return int'({HW'(0), 4'b0010});
        if (cnt == SPAN) return int'({HW'(0), 4'b0001});
        return int'({HW'(idx), 1'b1, idx[0], 2'b00});
    endfunction

    task automatic do_clear();
        @(negedge clk); clear = 1'b1;
        @(negedge clk); clear = 1'b0;
    endtask

    task automatic do_latch(input logic [N-1:0] v);
        @(negedge clk); tap_hits = v; latch = 1'b1;
        @(negedge clk); latch = 1'b0;
    endtask

    task automatic measure(input string req, input logic [N-1:0] v);
        do_clear();
        do_latch(v);
        check(req, outs(), expect_outs(v));
    endtask

    task automatic t_reset();
        check("R1 reset", outs(), 0);
    endtask

    task automatic t_single_odd();
        measure("R3 R4 single odd", 64'h20);
        check("R4 odd flag", int'(h_odd), 1);
        measure("R3 R4 tap 0", 64'h1);
        measure("R3 boundary top tap", 64'h1 << (SPAN-1));
    endtask

    task automatic t_multi();
        measure("R3 multi hit", (64'h1 << 12) | (64'h1 << 20) | (64'h1 << 30));
        check("R3 first index", int'(h_index), 12);
        measure("R3 adjacent", 64'h0000_0000_0000_0180);
        check("R4 odd via adjacent", int'(h_odd), 1);
    endtask

    task automatic t_upper_ignored();
        measure("R2 upper only", (64'h1 << 40) | (64'h1 << 63));
        check("R2 R5 overflow", int'(overflow), 1);
        measure("R2 upper plus lower", {32'hFFFF_FFFF, 32'h0000_0400});
        check("R2 index", int'(h_index), 10);
    endtask

    task automatic t_overflow();
        measure("R5 no hit", '0);
        check("R5 R7 valid low", int'(h_valid), 0);
    endtask

    task automatic t_underflow();
        measure("R6 lower all", {32'h0, 32'hFFFF_FFFF});
        check("R6 R7 underflow", int'(underflow), 1);
        measure("R6 all taps", '1);
        check("R7 not both", int'(overflow & underflow), 0);
    endtask

    task automatic t_timing_hold();
        do_clear();
        @(negedge clk); tap_hits = 64'h8; latch = 1'b1;
        #1 check("R8 not before edge", outs(), 0);
        @(negedge clk); latch = 1'b0;
        check("R8 after edge", int'(h_index), 3);
        tap_hits = 64'h2;
        @(negedge clk);
        check("R8 no strobe no change", int'(h_index), 3);
        do_latch(64'h4);
        @(negedge clk);
        check("R9 held ignores latch", int'(h_index), 3);
        do_clear();
        check("R1 clear empties", outs(), 0);
    endtask

    task automatic t_clear_priority();
        do_clear();
        @(negedge clk); tap_hits = 64'h10; latch = 1'b1; clear = 1'b1;
        @(negedge clk); latch = 1'b0; clear = 1'b0;
        check("R10 clear wins", outs(), 0);
        do_latch(64'h10);
        check("R10 still empty so capture", int'(h_index), 4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_odd();
        t_multi();
        t_upper_ignored();
        t_overflow();
        t_underflow();
        t_timing_hold();
        t_clear_priority();
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int c = 0; c < 5000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule